// File: doc/BRIEF.md
# Coarse-Step VGA Raster Timing Generator

This block produces the horizontal and vertical sync and blanking waveforms for a 640x480 raster at about 60 frames per second. It is built for displays whose pixels are eight dot-times wide. It never counts individual dots. Instead, it advances on a clock-enable tick that arrives at one eighth of the 25.175 MHz dot rate (about 3.147 MHz). Each horizontal step therefore spans eight screen pixels.

The horizontal counter runs through 100 coarse steps per line. The vertical counter advances once per line and runs through all 525 lines of the frame. Lines are counted one by one because the vertical back porch of 33 lines is not a multiple of eight.

Every sync and blanking output is held in a state bit. A single-value decode on the counter's next value sets that bit, and a second single-value decode clears it. A downstream pixel fetcher uses the two counts and the end-of-line strobe to address its memory.

Top module: `vga_coarse_timing`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, hcount_o and vcount_o are 0, hsync_no, vsync_no and blank_no are 1, and eol_o is 0.
- R2: hcount_o changes only on a clock edge at which tick_i is 1. On an edge with tick_i at 0, every count and every output except eol_o keeps its value.
- R3: hcount_o steps by one per tick through 0 to 99. The tick that arrives at 99 returns it to 0.
- R4: eol_o is 1 for exactly one clock cycle: the cycle that follows the edge at which hcount_o returned from 99 to 0. It is 0 at all other times.
- R5: vcount_o changes only at the edge where hcount_o wraps. It then steps by one through 0 to 524, and the wrap from line 524 returns it to 0.
- R6: hsync_no is 0 exactly while hcount_o is in the range 82 to 93 inclusive.
- R7: vsync_no is 0 exactly while vcount_o is 490 or 491.
- R8: blank_no is 0 exactly while hcount_o is 80 or above, or while vcount_o is 480 or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable at one eighth of the dot rate |
| hcount_o | output | 7 | Horizontal position in eight-pixel steps |
| vcount_o | output | 10 | Line number within the frame |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| blank_no | output | 1 | Low outside the visible area |
| eol_o | output | 1 | One-cycle strobe at the start of each line |

## Verification
The bench runs three tick patterns:
- A tick on every clock for more than a full frame. This walks every horizontal and vertical window edge, including both counter wraps, and exposes an off-by-one in any set or clear decode.
- A tick once every eight clocks, followed by an irregular pseudo-random tick pattern. These show that the state bits and the end-of-line strobe follow tick_i rather than the clock, and that idle clocks leave the outputs untouched.
- A long stretch with no tick, then a reset asserted in mid-frame. This checks that the counts hold without a tick and that every state bit returns to its idle level.

// File: rtl/vga_ct_pkg.sv
package vga_ct_pkg;
  // coarse horizontal timing, in eight-dot steps
  localparam int H_VIS_END   = 80;
  localparam int H_SYNC_BEG  = 82;
  localparam int H_SYNC_END  = 94;
  localparam int H_TOTAL     = 100;
  // vertical timing, in lines
  localparam int V_VIS_END   = 480;
  localparam int V_SYNC_BEG  = 490;
  localparam int V_SYNC_END  = 492;
  localparam int V_TOTAL     = 525;
endpackage

// File: rtl/vga_ct_counter.sv
module vga_ct_counter #(
  parameter int TOTAL = 100,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] next_o,
  output logic         wrap_o
);
  logic [W-1:0] count_q;

  assign wrap_o  = (count_q == W'(TOTAL - 1));
  assign next_o  = wrap_o ? '0 : count_q + W'(1);
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   count_q <= '0;
    else if (en_i) count_q <= next_o;
  end

  // R3 / R5: count never reaches the terminal value
  a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q < W'(TOTAL));
endmodule

// File: rtl/vga_ct_event_bit.sv
module vga_ct_event_bit #(
  parameter int W      = 7,
  parameter int SET_AT = 80,
  parameter int CLR_AT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] next_i,
  output logic         state_o
);
  logic state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else if (en_i) begin
      if (next_i == W'(SET_AT))      state_q <= 1'b1;
      else if (next_i == W'(CLR_AT)) state_q <= 1'b0;
    end
  end

  assign state_o = state_q;

  // R2: state only moves on an enabled edge
  a_r2_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q));
endmodule

// File: rtl/vga_coarse_timing.sv
module vga_coarse_timing
  import vga_ct_pkg::*;
#(
  parameter int  H_BLANK_AT = H_VIS_END,
  parameter int  H_SYNC_AT  = H_SYNC_BEG,
  parameter int  H_SYNC_TO  = H_SYNC_END,
  parameter int  H_STEPS    = H_TOTAL,
  parameter int  V_BLANK_AT = V_VIS_END,
  parameter int  V_SYNC_AT  = V_SYNC_BEG,
  parameter int  V_SYNC_TO  = V_SYNC_END,
  parameter int  V_LINES    = V_TOTAL,
  localparam int HW         = $clog2(H_STEPS),
  localparam int VW         = $clog2(V_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [HW-1:0] hcount_o,
  output logic [VW-1:0] vcount_o,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          blank_no,
  output logic          eol_o
);
  logic [HW-1:0] h_cnt, h_nxt;
  logic [VW-1:0] v_cnt, v_nxt;
  logic          h_wrap, v_wrap, v_en;
  logic          h_blank, h_sync, v_blank, v_sync;
  logic          eol_q;

  assign v_en = tick_i & h_wrap;

  vga_ct_counter #(.TOTAL(H_STEPS), .W(HW)) i_hcnt (
    .clk_i, .rst_ni, .en_i(tick_i),
    .count_o(h_cnt), .next_o(h_nxt), .wrap_o(h_wrap));

  vga_ct_counter #(.TOTAL(V_LINES), .W(VW)) i_vcnt (
    .clk_i, .rst_ni, .en_i(v_en),
    .count_o(v_cnt), .next_o(v_nxt), .wrap_o(v_wrap));

  // horizontal event bits, decoded on the next count
  vga_ct_event_bit #(.W(HW), .SET_AT(H_BLANK_AT), .CLR_AT(0)) i_hblank (
    .clk_i, .rst_ni, .en_i(tick_i), .next_i(h_nxt), .state_o(h_blank));

  vga_ct_event_bit #(.W(HW), .SET_AT(H_SYNC_AT), .CLR_AT(H_SYNC_TO)) i_hsync (
    .clk_i, .rst_ni, .en_i(tick_i), .next_i(h_nxt), .state_o(h_sync));

  // vertical event bits, stepped once per line
  vga_ct_event_bit #(.W(VW), .SET_AT(V_BLANK_AT), .CLR_AT(0)) i_vblank (
    .clk_i, .rst_ni, .en_i(v_en), .next_i(v_nxt), .state_o(v_blank));

  vga_ct_event_bit #(.W(VW), .SET_AT(V_SYNC_AT), .CLR_AT(V_SYNC_TO)) i_vsync (
    .clk_i, .rst_ni, .en_i(v_en), .next_i(v_nxt), .state_o(v_sync));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eol_q <= 1'b0;
    else         eol_q <= v_en;
  end

  assign hcount_o = h_cnt;
  assign vcount_o = v_cnt;
  assign hsync_no = ~h_sync;
  assign vsync_no = ~v_sync;
  assign blank_no = ~(h_blank | v_blank);
  assign eol_o    = eol_q;

  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(hcount_o) && $stable(vcount_o) && $stable(blank_no));
  a_r4_eol_at_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> hcount_o == '0);
  a_r4_eol_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> !eol_o);
  a_r5_line_moves_at_eol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vcount_o) |-> eol_o);
  a_r5_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_en && v_wrap |=> vcount_o == '0);
  a_r6_hsync_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> hcount_o >= HW'(H_SYNC_AT) && hcount_o < HW'(H_SYNC_TO));
  a_r7_vsync_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> vcount_o >= VW'(V_SYNC_AT) && vcount_o < VW'(V_SYNC_TO));
  a_r8_visible_not_blanked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o < HW'(H_BLANK_AT) && vcount_o < VW'(V_BLANK_AT) |-> blank_no);
endmodule

// File: tb/test_vga_coarse_timing.sv
module test_vga_coarse_timing;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [6:0] hcount_o;
  logic [9:0] vcount_o;
  logic       hsync_no, vsync_no, blank_no, eol_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int m_h = 0, m_v = 0, m_eol = 0;

  always #2 clk_i = ~clk_i;

  vga_coarse_timing i_vga_coarse_timing (
    .clk_i, .rst_ni, .tick_i, .hcount_o, .vcount_o,
    .hsync_no, .vsync_no, .blank_no, .eol_o);

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (h=%0d v=%0d)",
               req, what, act, exp, m_h, m_v);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_h = 0; m_v = 0; m_eol = 0;
    end else begin
      m_eol = 0;
      if (tick_i) begin
        if (m_h == 99) begin
          m_h = 0; m_eol = 1;
          m_v = (m_v == 524) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      chk("R3", "hcount", int'(hcount_o), m_h);
      chk("R5", "vcount", int'(vcount_o), m_v);
      chk("R4", "eol", int'(eol_o), m_eol);
      chk("R6", "hsync_n", int'(hsync_no), (m_h >= 82 && m_h < 94) ? 0 : 1);
      chk("R7", "vsync_n", int'(vsync_no), (m_v >= 490 && m_v < 492) ? 0 : 1);
      chk("R8", "blank_n", int'(blank_no), (m_h >= 80 || m_v >= 480) ? 0 : 1);
    end
  end

  task automatic r1_idle_check();
    chk("R1", "hcount", int'(hcount_o), 0);
    chk("R1", "vcount", int'(vcount_o), 0);
    chk("R1", "hsync_n", int'(hsync_no), 1);
    chk("R1", "vsync_n", int'(vsync_no), 1);
    chk("R1", "blank_n", int'(blank_no), 1);
    chk("R1", "eol", int'(eol_o), 0);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int hold_h, hold_v;
    repeat (4) @(negedge clk_i);
    r1_idle_check();
    rst_ni = 1'b1;
    @(negedge clk_i);
    r1_idle_check();
    // dense ticks: one full frame plus margin
    tick_i = 1'b1;
    repeat (52700) @(negedge clk_i);
    // divide-by-eight tick
    for (int i = 0; i < 2400; i++) begin
      tick_i = (i % 8) == 7;
      @(negedge clk_i);
    end
    // irregular ticks
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick_i = lfsr[0];
      @(negedge clk_i);
    end
    // R2: no tick for a while, outputs hold
    tick_i = 1'b0;
    @(negedge clk_i);
    hold_h = int'(hcount_o);
    hold_v = int'(vcount_o);
    repeat (60) @(negedge clk_i);
    chk("R2", "hcount held", int'(hcount_o), hold_h);
    chk("R2", "vcount held", int'(vcount_o), hold_v);
    // run into blanking, then reset mid-frame
    tick_i = 1'b1;
    repeat (30100) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    r1_idle_check();
    @(negedge clk_i);
    r1_idle_check();
    rst_ni = 1'b1;
    repeat (300) @(negedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule